// File: doc/BRIEF.md
# Four-Bit Single-Cycle Processor Core

This block is a small processor that finishes one instruction on every rising clock edge. Instructions are 12 bits wide and come from an 8-word program image. The image is a parameter of the core, so each instance carries its own fixed program. A 3-bit program counter selects the word. The fetched word is decoded in the same cycle. Operands come from an 8-entry file of 4-bit registers. The result, the flags and the next program counter are all written back at the next edge.

The instruction set has four kinds of instruction:
- loading a constant into a register;
- a register-with-register operation chosen by a 4-bit function code;
- replacing a register with its two's-complement negative;
- a branch taken when a chosen register holds zero.

Register 0 is wired to zero. A branch on register 0 is therefore always taken. For observation, the core shows its program counter, the zero and overflow flags, and the value of any register picked by a select input.

Top module: `nanocore4`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the program counter to 0, clears every register and clears both flags.
- R2: A word with bits [11:10]=10 writes its bits [3:0] into the register named by bits [9:7]. Bits [6:4] are not looked at.
- R3: A word with bits [11:10]=00 reads Ra from bits [9:7] and Rb from bits [6:4]. It writes back into Ra the function in bits [3:0], as follows:
  - 0000: Ra+Rb
  - 0001: Ra-Rb
  - 0010: AND
  - 0011: OR
  - 0100: XOR
  - 0101: the low 4 bits of Ra*Rb
- R4: Function code 0111 compares Ra against Rb. It sets the flags as Ra-Rb would, and it writes no register.
- R5: A word with bits [11:10]=01 replaces the register named by bits [9:7] with its two's-complement negative, modulo 16.
- R6: A word with bits [11:10]=11 loads bits [2:0] into the program counter when the register named by bits [9:7] reads zero. Otherwise the program counter increments.
- R7: Every instruction that is not a taken branch adds one to the program counter. The count wraps from 7 to 0.
- R8: Register 0 always reads zero. Any write aimed at it is dropped.
- R9: The following instructions update the flags:
  - the six register-with-register operations;
  - the compare;
  - the negate.
  The zero flag is set when the 4-bit result is 0. The overflow flag reports signed two's-complement overflow for add, subtract, compare and negate. It is cleared for AND, OR, XOR and multiply.
- R10: Constant loads and branches leave both flags unchanged. Function codes 0110 and 1000 to 1111 change no register and no flag.
- R11: obs_val_o shows, without a clock delay, the current value of the register named by obs_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| obs_sel | input | 3 | Register chosen for observation |
| pc_o | output | 3 | Current program counter |
| obs_val_o | output | 4 | Value of the register chosen by obs_sel |
| zero_o | output | 1 | Zero flag |
| ovf_o | output | 1 | Overflow flag |

## Verification
The only inputs that steer the core are its program and its reset. The hardest situations to reach are therefore those that depend on data:
- negating -8;
- an add that carries out of +7;
- a branch that falls through and later is taken.

The bench builds two instances with different programs. The first counts a register up through the +7 to -8 boundary until the count wraps to zero and the branch fires. The second feeds a running sum into subtract and negate, so that it walks through many signed values, and it finishes on a reserved code and a wrap from address 7 to 0. A behavioural model runs beside each instance. Every cycle, the bench sweeps obs_sel across all eight registers and compares each value, together with the program counter and the flags. A reset applied in the middle of the run is also checked.

// File: rtl/np_pkg.sv
package np_pkg;
    localparam int DATA_W  = 4;
    localparam int INSTR_W = 12;
    localparam int REG_N   = 8;
    localparam int ROM_N   = 8;
    localparam int REG_AW  = $clog2(REG_N);
    localparam int PC_W    = $clog2(ROM_N);

    localparam logic [1:0] MAJ_RR  = 2'b00;
    localparam logic [1:0] MAJ_NEG = 2'b01;
    localparam logic [1:0] MAJ_LDI = 2'b10;
    localparam logic [1:0] MAJ_JZ  = 2'b11;

    localparam logic [3:0] FN_ADD = 4'b0000;
    localparam logic [3:0] FN_SUB = 4'b0001;
    localparam logic [3:0] FN_AND = 4'b0010;
    localparam logic [3:0] FN_OR  = 4'b0011;
    localparam logic [3:0] FN_XOR = 4'b0100;
    localparam logic [3:0] FN_MUL = 4'b0101;
    localparam logic [3:0] FN_CMP = 4'b0111;

    typedef enum logic [3:0] {
        K_LDI, K_NEG, K_JZ, K_ADD, K_SUB, K_AND,
        K_OR,  K_XOR, K_MUL, K_CMP, K_NOP
    } kind_e;

    typedef struct packed {
        kind_e               kind;
        logic [REG_AW-1:0]   ra;
        logic [REG_AW-1:0]   rb;
        logic [DATA_W-1:0]   imm;
        logic [PC_W-1:0]     target;
        logic                wr_en;
        logic                flag_en;
        logic                is_jump;
    } ctrl_t;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            zf;
        logic            vf;
    } core_t;
endpackage

// File: rtl/np_decode.sv
module np_decode
    import np_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output ctrl_t              ctrl
);
    always_comb begin
        ctrl         = '0;
        ctrl.kind    = K_NOP;
        ctrl.ra      = instr[9:7];
        ctrl.rb      = instr[6:4];
        ctrl.imm     = instr[3:0];
        ctrl.target  = instr[2:0];
        unique case (instr[11:10])
            MAJ_LDI: begin
                ctrl.kind  = K_LDI;
                ctrl.wr_en = 1'b1;
            end
            MAJ_NEG: begin
                ctrl.kind    = K_NEG;
                ctrl.wr_en   = 1'b1;
                ctrl.flag_en = 1'b1;
            end
            MAJ_JZ: begin
                ctrl.kind    = K_JZ;
                ctrl.is_jump = 1'b1;
            end
            default: begin
                ctrl.wr_en   = 1'b1;
                ctrl.flag_en = 1'b1;
                case (instr[3:0])
                    FN_ADD:  ctrl.kind = K_ADD;
                    FN_SUB:  ctrl.kind = K_SUB;
                    FN_AND:  ctrl.kind = K_AND;
                    FN_OR:   ctrl.kind = K_OR;
                    FN_XOR:  ctrl.kind = K_XOR;
                    FN_MUL:  ctrl.kind = K_MUL;
                    FN_CMP: begin
                        ctrl.kind  = K_CMP;
                        ctrl.wr_en = 1'b0;
                    end
                    default: begin
                        ctrl.kind    = K_NOP;
                        ctrl.wr_en   = 1'b0;
                        ctrl.flag_en = 1'b0;
                    end
                endcase
            end
        endcase
    end
endmodule

// File: rtl/np_alu.sv
module np_alu
    import np_pkg::*;
(
    input  kind_e             kind,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] imm,
    output logic [DATA_W-1:0] res,
    output logic              ovf
);
    localparam int EXT_W  = DATA_W + 1;
    localparam int PROD_W = 2 * DATA_W;

    logic [EXT_W-1:0]  a_x;
    logic [EXT_W-1:0]  b_x;
    logic [EXT_W-1:0]  wide;
    logic [PROD_W-1:0] prod;

    assign a_x  = {a[DATA_W-1], a};
    assign b_x  = {b[DATA_W-1], b};
    assign prod = PROD_W'(a) * PROD_W'(b);

    always_comb begin
        wide = '0;
        res  = '0;
        ovf  = 1'b0;
        case (kind)
            K_ADD: begin
                wide = a_x + b_x;
                res  = wide[DATA_W-1:0];
                ovf  = wide[DATA_W] ^ wide[DATA_W-1];
            end
            K_SUB, K_CMP: begin
                wide = a_x - b_x;
                res  = wide[DATA_W-1:0];
                ovf  = wide[DATA_W] ^ wide[DATA_W-1];
            end
            K_NEG: begin
                wide = '0 - a_x;
                res  = wide[DATA_W-1:0];
                ovf  = wide[DATA_W] ^ wide[DATA_W-1];
            end
            K_AND:   res = a & b;
            K_OR:    res = a | b;
            K_XOR:   res = a ^ b;
            K_MUL:   res = prod[DATA_W-1:0];
            K_LDI:   res = imm;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/np_regfile.sv
module np_regfile
    import np_pkg::*;
#(
    parameter int NRD = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [REG_AW-1:0] raddr [NRD],
    output logic [DATA_W-1:0] rdata [NRD]
);
    logic [DATA_W-1:0] mem_d [REG_N];
    logic [DATA_W-1:0] mem_q [REG_N];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
        mem_d[0] = '0;
        if (rst) begin
            for (int i = 0; i < REG_N; i++) begin
                mem_d[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem_q[raddr[p]];
    end
endmodule

// File: rtl/nanocore4.sv
module nanocore4
    import np_pkg::*;
#(
    parameter logic [ROM_N*INSTR_W-1:0] PROG_IMAGE = 96'hC02_C80_034_215_191_0A0_901_887
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] obs_sel,
    output logic [PC_W-1:0]   pc_o,
    output logic [DATA_W-1:0] obs_val_o,
    output logic              zero_o,
    output logic              ovf_o
);
    localparam int NRD = 3;

    core_t               core_d, core_q;
    ctrl_t               ctrl;
    logic [INSTR_W-1:0]  instr;
    logic [DATA_W-1:0]   ra_val;
    logic [DATA_W-1:0]   rb_val;
    logic [DATA_W-1:0]   res;
    logic                ovf;
    logic [REG_AW-1:0]   raddr [NRD];
    logic [DATA_W-1:0]   rdata [NRD];

    assign instr = PROG_IMAGE[core_q.pc*INSTR_W +: INSTR_W];

    np_decode u_dec (
        .instr (instr),
        .ctrl  (ctrl)
    );

    assign raddr[0] = ctrl.ra;
    assign raddr[1] = ctrl.rb;
    assign raddr[2] = obs_sel;
    assign ra_val   = rdata[0];
    assign rb_val   = rdata[1];

    np_regfile #(.NRD(NRD)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (ctrl.wr_en),
        .waddr (ctrl.ra),
        .wdata (res),
        .raddr (raddr),
        .rdata (rdata)
    );

    np_alu u_alu (
        .kind (ctrl.kind),
        .a    (ra_val),
        .b    (rb_val),
        .imm  (ctrl.imm),
        .res  (res),
        .ovf  (ovf)
    );

    always_comb begin
        core_d    = core_q;
        core_d.pc = core_q.pc + 1'b1;
        if (ctrl.is_jump && (ra_val == '0)) begin
            core_d.pc = ctrl.target;
        end
        if (ctrl.flag_en) begin
            core_d.zf = (res == '0);
            core_d.vf = ovf;
        end
        if (rst) begin
            core_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        core_q <= core_d;
    end

    assign pc_o      = core_q.pc;
    assign zero_o    = core_q.zf;
    assign ovf_o     = core_q.vf;
    assign obs_val_o = rdata[2];
endmodule

// File: rtl/nanocore4_chk.sv
module nanocore4_chk
    import np_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [INSTR_W-1:0] instr,
    input logic [DATA_W-1:0] ra_val,
    input logic [REG_AW-1:0] obs_sel,
    input logic [PC_W-1:0]   pc_o,
    input logic [DATA_W-1:0] obs_val_o,
    input logic              zero_o,
    input logic              ovf_o
);
    logic is_jz, is_ldi, arith;
    assign is_jz  = (instr[11:10] == 2'b11);
    assign is_ldi = (instr[11:10] == 2'b10);
    assign arith  = (instr[11:10] == 2'b01) ||
                    (instr[11:10] == 2'b00 &&
                     (instr[3:0] == 4'b0000 || instr[3:0] == 4'b0001 || instr[3:0] == 4'b0111));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && !zero_o && !ovf_o));

    // R7
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !is_jz |=> pc_o == $past(pc_o) + 1'b1);

    // R6
    jump_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (is_jz && ra_val == '0) |=> pc_o == $past(instr[2:0]));

    // R8
    r0_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (obs_sel == '0) |-> (obs_val_o == '0));

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (is_jz || is_ldi) |=> $stable({zero_o, ovf_o}));

    // R9
    ovf_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_o) |-> $past(arith));
endmodule

bind nanocore4 nanocore4_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .instr     (instr),
    .ra_val    (ra_val),
    .obs_sel   (obs_sel),
    .pc_o      (pc_o),
    .obs_val_o (obs_val_o),
    .zero_o    (zero_o),
    .ovf_o     (ovf_o)
);

// File: tb/sim_nanocore4.sv
module sim_nanocore4;
    localparam int PERIOD = 20;

    function automatic logic [11:0] e_rr(int a, int b, int f);
        return {2'b00, 3'(a), 3'(b), 4'(f)};
    endfunction
    function automatic logic [11:0] e_ldi(int d, int v);
        return {2'b10, 3'(d), 3'b000, 4'(v)};
    endfunction
    function automatic logic [11:0] e_neg(int r);
        return {2'b01, 3'(r), 7'b0};
    endfunction
    function automatic logic [11:0] e_jz(int r, int t);
        return {2'b11, 3'(r), 4'b0000, 3'(t)};
    endfunction

    // counts R1 up through the signed boundary, branches back when it wraps to 0
    localparam logic [95:0] PROG_A = {e_jz(0, 2), e_jz(1, 0), e_rr(0, 3, 4), e_rr(4, 1, 5),
                                      e_rr(3, 1, 1), e_rr(1, 2, 0), e_ldi(2, 1), e_ldi(1, 7)};
    // running sum feeding sub/neg/or/and/cmp, reserved code, wrap 7->0
    localparam logic [95:0] PROG_B = {e_rr(6, 7, 15), e_rr(6, 7, 7), e_rr(5, 6, 2), e_rr(5, 4, 3),
                                      e_neg(4), e_rr(4, 6, 1), e_rr(6, 7, 0), e_ldi(7, 5)};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sel0 = '0, sel1 = '0;
    logic [2:0] pc0, pc1;
    logic [3:0] val0, val1;
    logic       z0, z1, v0, v1;

    nanocore4 #(.PROG_IMAGE(PROG_A)) u0 (
        .clk(clk), .rst(rst), .obs_sel(sel0), .pc_o(pc0),
        .obs_val_o(val0), .zero_o(z0), .ovf_o(v0));
    nanocore4 #(.PROG_IMAGE(PROG_B)) u1 (
        .clk(clk), .rst(rst), .obs_sel(sel1), .pc_o(pc1),
        .obs_val_o(val1), .zero_o(z1), .ovf_o(v1));

    always #(PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [11:0] pg [2][8];
    int mr [2][8];
    int mp [2], mz [2], mv [2];
    string rtag [2], ptag [2], ftag [2];

    task automatic check(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic int sx(int v);
        return (v > 7) ? v - 16 : v;
    endfunction

    task automatic model_reset(int k);
        for (int i = 0; i < 8; i++) mr[k][i] = 0;
        mp[k] = 0; mz[k] = 0; mv[k] = 0;
        rtag[k] = "R1"; ptag[k] = "R1"; ftag[k] = "R1";
    endtask

    task automatic model_step(int k);
        logic [11:0] ins;
        int a, b, f, va, vb, r, s, npc;
        bit wr, fl;
        ins = pg[k][mp[k]];
        a = int'(ins[9:7]); b = int'(ins[6:4]); f = int'(ins[3:0]);
        va = mr[k][a]; vb = mr[k][b];
        npc = (mp[k] + 1) % 8;
        wr = 0; fl = 0; r = 0; s = 0;
        ptag[k] = "R7"; ftag[k] = "R10";
        case (ins[11:10])
            2'b10: begin r = f; wr = 1; rtag[k] = "R2"; end
            2'b01: begin
                s = -sx(va); r = s & 15; wr = 1; fl = 1;
                rtag[k] = "R5"; ftag[k] = "R9";
            end
            2'b11: begin
                if (va == 0) npc = int'(ins[2:0]);
                ptag[k] = "R6"; rtag[k] = "R6";
            end
            default: begin
                rtag[k] = "R3"; fl = 1; wr = 1; ftag[k] = "R9";
                case (f)
                    0: s = sx(va) + sx(vb);
                    1: s = sx(va) - sx(vb);
                    2: s = va & vb;
                    3: s = va | vb;
                    4: s = va ^ vb;
                    5: s = (va * vb) & 15;
                    7: begin s = sx(va) - sx(vb); wr = 0; rtag[k] = "R4"; ftag[k] = "R4"; end
                    default: begin wr = 0; fl = 0; rtag[k] = "R10"; end
                endcase
                r = s & 15;
                if (f == 2 || f == 3 || f == 4 || f == 5) s = 0;
            end
        endcase
        if (fl) begin
            mz[k] = (r == 0) ? 1 : 0;
            mv[k] = (s > 7 || s < -8) ? 1 : 0;
        end
        if (wr && a != 0) mr[k][a] = r;
        if (wr && a == 0) rtag[k] = "R8";
        mp[k] = npc;
    endtask

    task automatic compare_all();
        check(pc0 == 3'(mp[0]), ptag[0], "u0 pc", int'(pc0), mp[0]);
        check(pc1 == 3'(mp[1]), ptag[1], "u1 pc", int'(pc1), mp[1]);
        check(z0 == 1'(mz[0]) && v0 == 1'(mv[0]), ftag[0], "u0 flags",
              int'({z0, v0}), mz[0] * 2 + mv[0]);
        check(z1 == 1'(mz[1]) && v1 == 1'(mv[1]), ftag[1], "u1 flags",
              int'({z1, v1}), mz[1] * 2 + mv[1]);
        for (int s = 0; s < 8; s++) begin
            sel0 = 3'(s); sel1 = 3'(s);
            #1;
            // R11: combinational observation of every register
            check(val0 == 4'(mr[0][s]), (s == 0) ? "R8" : rtag[0], "u0 reg", int'(val0), mr[0][s]);
            check(val1 == 4'(mr[1][s]), (s == 0) ? "R8" : rtag[1], "u1 reg", int'(val1), mr[1][s]);
        end
    endtask

    task automatic run_cycles(int n);
        for (int c = 0; c < n; c++) begin
            @(posedge clk);
            for (int k = 0; k < 2; k++) begin
                if (rst) model_reset(k);
                else model_step(k);
            end
            @(negedge clk);
            compare_all();
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            pg[0][i] = PROG_A[i*12 +: 12];
            pg[1][i] = PROG_B[i*12 +: 12];
        end
        model_reset(0); model_reset(1);
        rst = 1'b1;
        run_cycles(3);           // R1 reset state
        rst = 1'b0;
        run_cycles(70);
        rst = 1'b1;              // R1 mid-run reset
        run_cycles(2);
        rst = 1'b0;
        run_cycles(50);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule